// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a byte-wide non-volatile memory that answers on an I2C bus. The bus arrives as two raw inputs, the clock line and the data line. The block drives back one output that, when high, pulls the data line low. It never drives the line high. The design samples the bus with its own system clock, which must run well above the bus bit rate. Three strap inputs set the low bits of the device address, so up to eight of these targets can share one bus. A lock input makes the whole array read-only.

A transfer begins with a start condition and a control byte. The control byte holds the fixed device code, the strap value and a direction bit. A write carries a one-byte word address and then up to eight data bytes. The data bytes collect in a page buffer and reach the array only at the stop condition. After that the target ignores its control byte for a fixed number of clocks, so a master can poll until the write has finished. Reads start at the internal pointer, which a write header can set first (a random read). Reads go on for as long as the master acknowledges. The pointer advances after every byte.

Top module: `eeprom_i2c_target`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sda_pull` is low. After reset the target is idle and not busy.
- R2: The target acknowledges a control byte only when bits 7..4 equal 4'b1010 and bits 3..1 equal `strap`. Bit 0 gives the direction: 0 means write and 1 means read. If the control byte does not match, the target never pulls the data line until the next start condition.
- R3: A write of control byte, word address and one data byte, followed by stop, stores the byte at that address. A later random read returns it. A random read is control(write), address, repeated start, then control(read).
- R4: The pointer advances by one after every byte read or accepted for writing. A read with no address phase (a current-address read) returns the location after the last one accessed.
- R5: A sequential read returns consecutive locations for as long as the master acknowledges. It wraps from address 255 to address 0 and ends when the master does not acknowledge.
- R6: The bytes of one write go to consecutive offsets within the 8-byte page selected by address bits 7..3. The offset, address bits 2..0, wraps from 7 to 0. A ninth byte overwrites the first byte of the write.
- R7: Buffered write data reaches the array only at a stop condition. A repeated start discards the data, leaves the array unchanged and does not make the target busy.
- R8: After a committing stop, the target does not acknowledge its control byte for `BUSY_CYCLES` clocks. After that it acknowledges again.
- R9: While `wr_lock` is high, the target does not acknowledge write data bytes and the array does not change. The target does not become busy. Control and address bytes are still acknowledged.
- R10: `sda_pull` changes only while the clock line is low. It never moves while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_pull | output | 1 | High pulls the data line low; low releases it |
| strap | input | 3 | Device address select bits |
| wr_lock | input | 1 | High makes the array read-only |

## Verification
The assertions watch, on every cycle, that the data line never moves while the clock line is high. They also check that the output is released out of reset, that no commit happens while the lock is high, and that the busy window lasts exactly `BUSY_CYCLES` clocks after each commit. Address matching, page wrap, discarding the buffer on a repeated start, pointer wrap and current-address reads depend on whole bus transactions. Only the bench's scenarios show them, by reading the array back through the bus and comparing against values derived from the requirements.

// File: rtl/ee_pkg.sv
// Package ee_pkg: shared types and constants of the I2C EEPROM target.
// Assumes 8-bit bytes and a 4-bit fixed device code in the control byte.
package ee_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } ee_state_t;
endpackage

// File: rtl/ee_line_sync.sv
// ee_line_sync: brings the raw bus lines into the clock domain and reports
// clock edges plus start and stop conditions as one-cycle pulses.
// Assumes the system clock samples each bus phase several times.
module ee_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_now,
    output logic start_cond,
    output logic stop_cond
);
    logic scl_m, scl_s, scl_q;
    logic sda_m, sda_s, sda_q;

    // Two-flop synchronizers plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_q} <= 3'b111;
            {sda_m, sda_s, sda_q} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_q} <= {scl_raw, scl_m, scl_s};
            {sda_m, sda_s, sda_q} <= {sda_raw, sda_m, sda_s};
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise   = scl_s & ~scl_q;
        scl_fall   = ~scl_s & scl_q;
        sda_now    = sda_s;
        start_cond = scl_s & scl_q & sda_q & ~sda_s;
        stop_cond  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/ee_busy_timer.sv
// ee_busy_timer: holds busy high for CYCLES clocks after each kick pulse.
// Assumes CYCLES >= 1.
module ee_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] remain;

    // Load on kick, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               remain <= '0;
        else if (kick)            remain <= CW'(CYCLES);
        else if (remain != '0)    remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/ee_array.sv
// ee_array: the storage array plus the page buffer that collects write bytes.
// On commit, every buffered lane is written into the page named by page_base.
// Assumes the array itself needs no reset; only the lane valid bits reset.
module ee_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    input  logic                     buf_wr,
    input  logic [PAGE_W-1:0]        buf_off,
    input  logic [7:0]               buf_byte,
    input  logic                     buf_clear,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic                     pending
);
    localparam int LANES = 1 << PAGE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]       mem    [DEPTH];
    logic [7:0]       lane_q [LANES];
    logic [LANES-1:0] lane_v;
    logic [LANES-1:0] lane_hit;

    // One select line per buffer lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = buf_wr && (buf_off == PAGE_W'(g));
    end

    // Array writes on commit and lane data capture.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (commit && lane_v[i]) mem[{page_base, PAGE_W'(i)}] <= lane_q[i];
            if (lane_hit[i])         lane_q[i] <= buf_byte;
        end
    end

    // Lane valid flags: set per byte, cleared by start or commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lane_v <= '0;
        else if (buf_clear || commit) lane_v <= '0;
        else                          lane_v <= lane_v | lane_hit;
    end

    assign rd_data = mem[rd_addr];
    assign pending = |lane_v;
endmodule

// File: rtl/eeprom_i2c_target.sv
// eeprom_i2c_target: I2C target with a byte-addressed array, page-buffered
// writes, strap-selected address, write lock and a post-write busy window.
// Assumes clk oversamples the bus; only ever pulls SDA low (open drain).
module eeprom_i2c_target
    import ee_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int BUSY_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [2:0] strap,
    input  logic       wr_lock
);
    localparam int PB_W = ADDR_W - PAGE_W;

    logic scl_rise, scl_fall, sda_now, start_cond, stop_cond;
    logic busy, commit, pending, buf_wr, rd_dir, m_ack;
    logic [7:0] rd_data, sr, tx;
    logic [3:0] bitcnt;
    logic [ADDR_W-1:0] ptr;
    logic [PB_W-1:0] page_base;
    logic [PAGE_W-1:0] off;
    ee_state_t state;

    ee_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_now(sda_now),
        .start_cond(start_cond), .stop_cond(stop_cond)
    );

    ee_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
    );

    ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
        .buf_wr(buf_wr), .buf_off(off), .buf_byte(sr),
        .buf_clear(start_cond), .commit(commit), .page_base(page_base),
        .pending(pending)
    );

    // Byte acceptance and commit strobes.
    always_comb begin
        buf_wr = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8) && !wr_lock;
        commit = stop_cond && pending && !wr_lock;
    end

    // Bus protocol state machine: shifting, acknowledge and pointer control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; bitcnt <= '0; sr <= '0; tx <= '0;
            ptr <= '0; page_base <= '0; off <= '0;
            sda_pull <= 1'b0; rd_dir <= 1'b0; m_ack <= 1'b0;
        end else if (start_cond) begin
            state <= ST_CTRL; bitcnt <= '0; sda_pull <= 1'b0;
        end else if (stop_cond) begin
            state <= ST_IDLE; sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_CTRL, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        sr     <= {sr[6:0], sda_now};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (state == ST_CTRL) begin
                            if (sr[7:4] == DEV_CODE && sr[3:1] == strap && !busy) begin
                                sda_pull <= 1'b1; rd_dir <= sr[0]; state <= ST_CTRL_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WADDR) begin
                            sda_pull  <= 1'b1;
                            ptr       <= sr[ADDR_W-1:0];
                            page_base <= sr[ADDR_W-1:PAGE_W];
                            off       <= sr[PAGE_W-1:0];
                            state     <= ST_WADDR_ACK;
                        end else if (!wr_lock) begin
                            sda_pull <= 1'b1;
                            off      <= off + 1'b1;
                            ptr      <= {page_base, off + PAGE_W'(1)};
                            state    <= ST_WDATA_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bitcnt   <= '0;
                        sda_pull <= 1'b0;
                        if (state == ST_CTRL_ACK && rd_dir) begin
                            tx <= rd_data; ptr <= ptr + 1'b1;
                            sda_pull <= ~rd_data[7]; state <= ST_RDATA;
                        end else if (state == ST_CTRL_ACK) begin
                            state <= ST_WADDR;
                        end else begin
                            state <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_pull <= 1'b0; state <= ST_RACK;
                        end else begin
                            sda_pull <= ~tx[3'd7 - bitcnt[2:0]];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_now;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            tx <= rd_data; ptr <= ptr + 1'b1; bitcnt <= '0;
                            sda_pull <= ~rd_data[7]; state <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: sda_pull <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
// eeprom_i2c_target_chk: protocol and timing properties of the target,
// bound into every instance. Assumes the reset and clock of the top module.
module eeprom_i2c_target_chk #(
    parameter int BUSY_CYCLES = 200
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_pull,
    input logic wr_lock,
    input logic commit,
    input logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    logic [CW-1:0] window;

    // Independent count of the cycles still owed to the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)               window <= '0;
        else if (commit)          window <= CW'(BUSY_CYCLES);
        else if (window != '0)    window <= window - 1'b1;
    end

    // R1
    reset_release_chk: assert property (@(posedge clk) !rst_n |=> !sda_pull);

    // R10
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && $past(scl_in, 2) && $past(scl_in, 3) && $past(scl_in, 4))
        |-> $stable(sda_pull));

    // R9
    locked_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |-> !commit);

    // R8
    busy_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (window != '0) |-> busy);

    // R8
    busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (window == '0) |-> !busy);
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
    .wr_lock(wr_lock), .commit(commit), .busy(busy)
);

// File: tb/sim_eeprom_i2c_target.sv
// sim_eeprom_i2c_target: bus-level bench acting as I2C master.
module sim_eeprom_i2c_target;
    localparam int H    = 8;
    localparam int BUSY = 600;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, lock = 1'b0;
    logic [2:0] strap = 3'd0;
    logic sda_pull, sda_line;
    int checks = 0, errors = 0;

    assign sda_line = m_sda & ~sda_pull;
    always #10 clk = ~clk;

    eeprom_i2c_target #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .strap(strap), .wr_lock(lock)
    );

    // {word address, data} pairs written one byte at a time and read back.
    localparam logic [15:0] VEC [8] = '{16'h00_3C, 16'h01_A5, 16'h07_00, 16'h18_E1,
                                        16'h40_77, 16'h80_FF, 16'hFD_12, 16'h55_C3};

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; hw();
        m_sda = 1'b0; hw();
        m_scl = 1'b0; hw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw();
        m_scl = 1'b1; hw();
        m_sda = 1'b1; hw();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw();
            m_scl = 1'b1; hw();
            m_scl = 1'b0;
        end
        m_sda = 1'b1; hw();
        m_scl = 1'b1; hw();
        ack = ~sda_line;
        m_scl = 1'b0; hw();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw();
            m_scl = 1'b1; hw();
            b = {b[6:0], sda_line};
            m_scl = 1'b0;
        end
        m_sda = ~give_ack; hw();
        m_scl = 1'b1; hw();
        m_scl = 1'b0; hw();
        m_sda = 1'b1;
    endtask

    task automatic ctrl(input logic rd, output logic ack);
        put_byte({4'b1010, strap, rd}, ack);
    endtask

    task automatic wait_ready();
        logic a;
        for (int k = 0; k < 60; k++) begin
            bus_start(); ctrl(1'b0, a); bus_stop();
            if (a) break;
        end
    endtask

    task automatic write_seq(input logic [7:0] addr, input logic [7:0] d [16],
                             input int n, output logic all_ack);
        logic a;
        bus_start(); ctrl(1'b0, a); all_ack = a;
        put_byte(addr, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            put_byte(d[i], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] addr, input int n, output logic [7:0] q [16]);
        logic a;
        bus_start(); ctrl(1'b0, a); put_byte(addr, a);
        bus_start(); ctrl(1'b1, a);
        for (int i = 0; i < n; i++) get_byte(i != n - 1, q[i]);
        bus_stop();
    endtask

    task automatic read_cur(output logic [7:0] b);
        logic a;
        bus_start(); ctrl(1'b1, a); get_byte(1'b0, b); bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d [16];
        logic [7:0] q [16];
        logic [7:0] b;
        logic a;

        repeat (5) @(negedge clk);
        chk("R1 pull during reset", sda_pull, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pull after reset", sda_pull, 0);
        bus_start(); ctrl(1'b0, a); bus_stop();
        chk("R1 not busy after reset", a, 1);

        // Vector walk: single-byte writes, then random reads (R3).
        foreach (VEC[v]) begin
            d[0] = VEC[v][7:0];
            write_seq(VEC[v][15:8], d, 1, a);
            chk("R3 write acknowledged", a, 1);
            wait_ready();
            read_seq(VEC[v][15:8], 1, q);
            chk("R3 random read data", q[0], VEC[v][7:0]);
        end

        // R8: control byte refused right after a commit, accepted later.
        d[0] = 8'h3D;
        write_seq(8'h55, d, 1, a);
        bus_start(); ctrl(1'b0, a); bus_stop();
        chk("R8 busy control nack", a, 0);
        repeat (BUSY) @(negedge clk);
        bus_start(); ctrl(1'b0, a); bus_stop();
        chk("R8 ack after busy window", a, 1);
        read_seq(8'h55, 1, q);
        chk("R8 committed data", q[0], 8'h3D);

        // R4: current-address read follows the last location read.
        read_seq(8'h00, 1, q);
        read_cur(b);
        chk("R4 current address read", b, 8'hA5);

        // R2: wrong code, wrong strap, then stays idle for the next byte.
        bus_start(); put_byte(8'hB0, a);
        chk("R2 wrong device code nack", a, 0);
        put_byte(8'h00, a);
        chk("R2 idle after mismatch", a, 0);
        bus_stop();
        strap = 3'b101;
        bus_start(); put_byte(8'hA0, a); bus_stop();
        chk("R2 wrong strap nack", a, 0);
        bus_start(); put_byte(8'hAA, a); bus_stop();
        chk("R2 matching strap ack", a, 1);

        // R6: nine bytes from offset 3 of page 0x10; the ninth overwrites the first.
        for (int i = 0; i < 9; i++) d[i] = 8'h20 + 8'(i);
        write_seq(8'h13, d, 9, a);
        chk("R6 page bytes acknowledged", a, 1);
        wait_ready();
        read_cur(b);
        chk("R4 pointer after page write", b, 8'h21);
        read_seq(8'h10, 9, q);
        chk("R6 offset 0", q[0], 8'h25);
        chk("R6 offset 2", q[2], 8'h27);
        chk("R6 offset 3 overwritten", q[3], 8'h28);
        chk("R6 offset 4", q[4], 8'h21);
        chk("R6 offset 7", q[7], 8'h24);
        chk("R6 next page untouched", q[8], 8'hE1);

        // R5: sequential read across the top of the array.
        d[0] = 8'h9E; d[1] = 8'h9F;
        write_seq(8'hFE, d, 2, a);
        wait_ready();
        read_seq(8'hFE, 3, q);
        chk("R5 read 0xFE", q[0], 8'h9E);
        chk("R5 read 0xFF", q[1], 8'h9F);
        chk("R5 wrap to 0x00", q[2], 8'h3C);
        read_cur(b);
        chk("R5 pointer after wrap", b, 8'hA5);

        // R7: repeated start discards buffered data, no busy window.
        bus_start(); ctrl(1'b0, a); put_byte(8'h40, a); put_byte(8'h5A, a);
        bus_start(); ctrl(1'b1, a); get_byte(1'b0, b); bus_stop();
        bus_start(); ctrl(1'b0, a); bus_stop();
        chk("R7 no busy after discard", a, 1);
        read_seq(8'h40, 1, q);
        chk("R7 array unchanged", q[0], 8'h77);

        // R9: locked writes refused, nothing stored, no busy window.
        lock = 1'b1;
        bus_start(); ctrl(1'b0, a);
        chk("R9 control ack while locked", a, 1);
        put_byte(8'h40, a);
        chk("R9 address ack while locked", a, 1);
        put_byte(8'h11, a);
        chk("R9 data nack while locked", a, 0);
        bus_stop();
        bus_start(); ctrl(1'b0, a); bus_stop();
        chk("R9 not busy after locked write", a, 1);
        lock = 1'b0;
        read_seq(8'h40, 1, q);
        chk("R9 locked data not stored", q[0], 8'h77);
        chk("R10 released at end", sda_pull, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule